// File: doc/BRIEF.md
# Asynchronous Memory Write Sequencer

This block is a bus master that performs single write accesses to asynchronous external memory. The host presents an address, a data word and a bank index. A request is taken when `req_valid` and `req_ready` are both high. The block then drives the memory pins through a fixed sequence, counted in clocks of its own bus clock. Address and one bank select go out first. The write strobe then falls and stays low for a programmable number of wait cycles. An acknowledge input can hold the strobe low for longer. After the strobe rises, address, select and data stay on the pins for a programmable number of hold cycles. One turnaround cycle follows, and then a single-cycle `done` pulse.

The wait and hold counts come from a configuration input and are captured when a request is taken, so changing them mid-access has no effect. The acknowledge pin is asynchronous and passes through a two-stage synchronizer. The read strobe is never used and stays inactive. The data bus leaves the block as a value plus an output enable; the pad that combines them is outside the block.

Top module: `async_wr_seq`

## Requirements
- R1: `mem_addr` carries the request address, and the select for the requested bank is driven low (`mem_sel_n[bank]` = 0, all other bits 1), exactly one clock before `mem_wr_n` falls.
- R2: With the synchronized acknowledge already high, `mem_wr_n` stays low for exactly W clocks. W is the captured `cfg_wait`, and a value of 0 is treated as 1.
- R3: `mem_doe` is never 1 before the strobe falls. It is 1 in every strobe-low cycle, in the cycle the strobe rises and in every hold cycle. While `mem_doe` is 1, `mem_dout` equals the request data. `mem_doe` drops in the cycle after the turnaround cycle.
- R4: After the strobe rises, the select and the address stay driven for exactly H clocks, where H is the captured `cfg_hold`. With H = 0 the select is released in the same cycle the strobe rises.
- R5: `mem_ack` passes through two flops before use, and the strobe never rises while the synchronized value is low. If `mem_ack` rises at strobe cycle K (counting the first low cycle as 0), the strobe lasts max(W, K+3) clocks.
- R6: `done` is a one-clock pulse. It is high in the cycle after the turnaround cycle, which is H+1 clocks after the cycle in which the strobe rises.
- R7: `req_ready` is high only while the block is idle. A `req_valid` that is raised and dropped while `req_ready` is low starts no access.
- R8: Between one strobe rise and the next strobe fall there are at least two high clocks. When the next request is already waiting, there are exactly H+3.
- R9: `cfg_wait` and `cfg_hold` are captured only when a request is taken; changing them during an access does not alter that access.
- R10: `mem_rd_n` is held at 1 at all times.
- R11: During and after reset, before any request: `req_ready`=1, `mem_wr_n`=1, `mem_sel_n` all ones, `mem_doe`=0, `done`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host write request |
| req_ready | output | 1 | Block is idle and can take a request |
| req_addr | input | AW | Write address |
| req_data | input | DW | Write data |
| req_bank | input | BW | Bank index, selects one `mem_sel_n` bit |
| cfg_wait | input | CW | Strobe wait count (0 treated as 1) |
| cfg_hold | input | CW | Hold count after the strobe rises |
| done | output | 1 | One-clock completion pulse |
| mem_addr | output | AW | Memory address bus |
| mem_sel_n | output | NBANK | Active-low bank selects |
| mem_wr_n | output | 1 | Active-low write strobe |
| mem_rd_n | output | 1 | Active-low read strobe, held inactive |
| mem_dout | output | DW | Data bus output value |
| mem_doe | output | 1 | Data bus output enable |
| mem_ack | input | 1 | Asynchronous acknowledge, low stretches the strobe |

## Verification
The bench builds the block with its defaults: AW=16, DW=16, NBANK=4 and CW=4. Four banks let every select bit be exercised. The 4-bit counts make the whole wait range 0..15 reachable, including the zero-wait clamp, and the whole hold range 0..15, including zero hold. Acknowledge release points from strobe cycle 0 to 7 cover both cases: the wait count finishing first and the synchronized acknowledge finishing first. Back-to-back requests exercise the exact turnaround spacing.

// File: rtl/async_wr_seq.sv
module async_wr_seq #(
  parameter int AW    = 16,
  parameter int DW    = 16,
  parameter int NBANK = 4,
  parameter int CW    = 4,
  localparam int BW   = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_data,
  input  logic [BW-1:0]    req_bank,
  input  logic [CW-1:0]    cfg_wait,
  input  logic [CW-1:0]    cfg_hold,
  output logic             done,
  output logic [AW-1:0]    mem_addr,
  output logic [NBANK-1:0] mem_sel_n,
  output logic             mem_wr_n,
  output logic             mem_rd_n,
  output logic [DW-1:0]    mem_dout,
  output logic             mem_doe,
  input  logic             mem_ack
);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_STROBE, S_HOLD, S_TURN} st_t;

  st_t            st;
  logic [AW-1:0]  addr_q;
  logic [DW-1:0]  data_q;
  logic [BW-1:0]  bank_q;
  logic [CW-1:0]  wait_q, hold_q, wcnt, hcnt;
  logic           ack_m, ack_s, doe_q, done_q;
  logic           sel_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      addr_q <= '0;
      data_q <= '0;
      bank_q <= '0;
      wait_q <= CW'(1);
      hold_q <= '0;
      wcnt   <= '0;
      hcnt   <= '0;
      ack_m  <= 1'b0;
      ack_s  <= 1'b0;
      doe_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      ack_m  <= mem_ack;
      ack_s  <= ack_m;
      done_q <= (st == S_TURN);
      doe_q  <= (st == S_SETUP) || (st == S_STROBE) || (st == S_HOLD);
      case (st)
        S_IDLE: if (req_valid) begin
          addr_q <= req_addr;
          data_q <= req_data;
          bank_q <= req_bank;
          wait_q <= (cfg_wait == '0) ? CW'(1) : cfg_wait;
          hold_q <= cfg_hold;
          st     <= S_SETUP;
        end
        S_SETUP: begin
          wcnt <= wait_q - 1'b1;
          st   <= S_STROBE;
        end
        S_STROBE: begin
          if (wcnt != '0) wcnt <= wcnt - 1'b1;
          else if (ack_s) begin
            if (hold_q != '0) begin
              hcnt <= hold_q - 1'b1;
              st   <= S_HOLD;
            end else begin
              st   <= S_TURN;
            end
          end
        end
        S_HOLD: begin
          if (hcnt == '0) st <= S_TURN;
          else            hcnt <= hcnt - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign sel_on    = (st == S_SETUP) || (st == S_STROBE) || (st == S_HOLD);
  assign req_ready = (st == S_IDLE);
  assign mem_addr  = addr_q;
  assign mem_dout  = data_q;
  assign mem_doe   = doe_q;
  assign mem_wr_n  = (st != S_STROBE);
  assign mem_rd_n  = 1'b1;
  assign done      = done_q;
  assign mem_sel_n = sel_on ? ~(NBANK'(1) << bank_q) : '1;

  logic [CW:0] lo_run;
  logic [1:0]  hi_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_run <= '0;
      hi_run <= 2'd3;
    end else begin
      lo_run <= mem_wr_n ? '0 : ((&lo_run) ? lo_run : lo_run + 1'b1);
      hi_run <= !mem_wr_n ? 2'd0 : ((hi_run == 2'd3) ? hi_run : hi_run + 1'b1);
    end
  end

  // R1
  setup_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_wr_n) |-> $past(mem_sel_n) != '1);

  // R2
  wait_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_wr_n) |-> lo_run >= {1'b0, wait_q});

  // R3
  data_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_doe) |-> !mem_wr_n);

  // R5
  ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_wr_n) |-> $past(ack_s));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready && mem_sel_n == '1);

  // R8
  turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_wr_n) |-> hi_run >= 2'd2);

endmodule

// File: tb/async_wr_seq_bench.sv
module async_wr_seq_bench;
  localparam int CLK_P = 10;
  localparam int AW = 16, DW = 16, NBANK = 4, CW = 4, BW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready, done;
  logic [AW-1:0] req_addr = '0, mem_addr;
  logic [DW-1:0] req_data = '0, mem_dout;
  logic [BW-1:0] req_bank = '0;
  logic [CW-1:0] cfg_wait = '0, cfg_hold = '0;
  logic [NBANK-1:0] mem_sel_n;
  logic mem_wr_n, mem_rd_n, mem_doe;
  logic mem_ack = 1'b1;

  async_wr_seq #(.AW(AW), .DW(DW), .NBANK(NBANK), .CW(CW)) u_async_wr_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data), .req_bank(req_bank),
    .cfg_wait(cfg_wait), .cfg_hold(cfg_hold), .done(done),
    .mem_addr(mem_addr), .mem_sel_n(mem_sel_n), .mem_wr_n(mem_wr_n),
    .mem_rd_n(mem_rd_n), .mem_dout(mem_dout), .mem_doe(mem_doe), .mem_ack(mem_ack));

  always #(CLK_P/2) clk = ~clk;

  int checks = 0, fails = 0;
  int hi_cnt = 0, last_gap = -1;
  logic prev_wr = 1'b1;

  always @(negedge clk) if (rst_n) begin
    if (prev_wr && !mem_wr_n) begin last_gap = hi_cnt; hi_cnt = 0; end
    else if (mem_wr_n) hi_cnt++;
    prev_wr = mem_wr_n;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_strobe(input int w, input int k);
    int we = (w == 0) ? 1 : w;
    if (k < 0) return we;
    return (we > k + 3) ? we : k + 3;
  endfunction

  function automatic logic [NBANK-1:0] exp_sel(input int b);
    return ~(NBANK'(1) << b);
  endfunction

  task automatic run(input int addr, input int data, input int bank,
                     input int w, input int h, input int k, input bit ghost);
    int n, m, ln;
    bit bad;
    logic want;
    want = (k < 0);
    if (mem_ack != want) begin mem_ack = want; repeat (3) @(negedge clk); end
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = AW'(addr); req_data = DW'(data);
    req_bank = BW'(bank); cfg_wait = CW'(w); cfg_hold = CW'(h);
    @(negedge clk);
    req_valid = ghost; req_addr = ~AW'(addr);
    cfg_wait = CW'($urandom); cfg_hold = CW'($urandom);
    // R1: one setup cycle with select and address, strobe high, bus off
    chk(mem_wr_n && mem_sel_n == exp_sel(bank) && mem_addr == AW'(addr) && !mem_doe && !req_ready,
        "R1 setup", int'(mem_sel_n), int'(exp_sel(bank)));
    @(negedge clk);
    req_valid = 1'b0;
    n = 0; bad = 0;
    while (!mem_wr_n && n < 200) begin
      if (!(mem_doe && mem_dout == DW'(data) && mem_sel_n == exp_sel(bank) && mem_addr == AW'(addr)))
        bad = 1;
      if (k >= 0 && n == k) mem_ack = 1'b1;
      n++;
      @(negedge clk);
    end
    chk(!bad, "R3 bus during strobe", int'(bad), 0);
    ln = exp_strobe(w, k);
    if (k < 0) chk(n == ln, "R2 R9 strobe length", n, ln);
    else       chk(n == ln, "R5 R9 ack stretch", n, ln);
    chk(mem_doe && mem_dout == DW'(data), "R3 data past rise", int'(mem_doe), 1);
    m = 0; bad = 0;
    while (mem_sel_n != '1 && m < 40) begin
      if (!(mem_doe && mem_dout == DW'(data) && mem_addr == AW'(addr) && mem_wr_n)) bad = 1;
      m++;
      @(negedge clk);
    end
    chk(m == h && !bad, "R4 hold cycles", m, h);
    chk(!done && mem_doe && !req_ready, "R6 turnaround", int'(done), 0);
    @(negedge clk);
    chk(done && !mem_doe && req_ready && mem_rd_n, "R6 done pulse", int'(done), 1);
    if (ghost) begin
      bad = 0;
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        if (mem_sel_n != '1 || !mem_wr_n || done) bad = 1;
      end
      // R7: request raised while busy started nothing
      chk(!bad, "R7 busy request ignored", int'(bad), 0);
    end
  endtask

  task automatic finish_up;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_up();
  end

  initial begin
    int hp;
    void'($urandom(32'h5eed_0017));
    repeat (2) @(negedge clk);
    // R11
    chk(req_ready && mem_wr_n && mem_sel_n == '1 && !mem_doe && !done,
        "R11 reset state", int'(mem_sel_n), 15);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(req_ready && mem_wr_n && mem_sel_n == '1 && !mem_doe && !done && mem_rd_n,
        "R11 R10 idle after reset", int'(req_ready), 1);

    run(16'h1234, 16'hbeef, 0, 0, 0, -1, 0);
    run(16'h00ff, 16'h5a5a, 3, 15, 15, -1, 0);
    run(16'h0a0a, 16'h1111, 1, 5, 0, 2, 0);
    run(16'h0b0b, 16'h2222, 2, 1, 3, 6, 0);
    run(16'h0c0c, 16'h3333, 1, 4, 2, 0, 1);

    run(16'h4000, 16'h0001, 2, 2, 2, -1, 0);
    run(16'h4001, 16'h0002, 0, 3, 1, -1, 0);
    // R8: second request waiting, spacing is hold + 3
    chk(last_gap == 5, "R8 back-to-back gap", last_gap, 5);

    for (int t = 0; t < 80; t++) begin
      int w, h, k;
      w = $urandom % 16;
      h = $urandom % 16;
      k = ($urandom % 3 == 0) ? int'($urandom % 8) : -1;
      hp = h;
      run($urandom, $urandom, $urandom % NBANK, w, h, k, ($urandom % 4) == 0);
      if (k < 0 && t > 0) chk(last_gap >= 2, "R8 minimum gap", last_gap, 2);
    end
    if (hp >= 0) chk(mem_rd_n, "R10 read strobe idle", int'(mem_rd_n), 1);
    repeat (4) @(negedge clk);
    finish_up();
  end
endmodule